// File: doc/BRIEF.md
# Transmit Queue Interrupt Moderator

This block decides when a single transmit queue should interrupt the host. It counts completed frames and raises a utilization interrupt once enough frames have been seen. How many is enough depends on how busy the link is: the current utilization percentage is compared against three rising limits, and the resulting band picks one of four frame-count thresholds. The percentage itself is measured outside the block.

Alongside the frame counter runs an interval timer that advances on a one-microsecond tick. When an interval expires, the timer interrupt fires. In normal mode it fires only if frames completed during that interval. In continuous mode it fires on every expiry. With auto-cancel set, any utilization interrupt restarts the interval from zero. The two interrupts leave the block on separate pins, and a global enable silences both of them.

Top module: `txq_irq_moderator`

## Requirements
- R1: Each frame strobe selects a band from the utilization value present in that cycle. The band is the first of A, B, C whose limit is at or above the value, and D if none is. Limit A sits at `lim_i[6:0]`, B at `[13:7]` and C at `[20:14]`. `band_o` shows the band as A=0, B=1, C=2, D=3, starting in the cycle after the strobe.
- R2: Each frame strobe adds one to a saturating frame counter. If the new count is at or above the selected band's threshold, `util_irq_o` is high for the one cycle after the strobe. The thresholds sit in `thr_i` as A `[15:0]`, B `[31:16]`, C `[47:32]` and D `[63:48]`.
- R3: The frame counter returns to zero when a utilization interrupt fires. It carries across band changes when no interrupt fires.
- R4: The interval counter advances only on `us_tick_i`. An interval of N expires on the N-th tick since the last restart, and the timer pulse appears in the cycle after that tick. An interval of 0 produces no timer pulses.
- R5: With continuous mode off, an expiry raises `tmr_irq_o` only if a frame strobe arrived since the previous expiry, counting the expiring cycle itself.
- R6: With continuous mode on, every expiry raises `tmr_irq_o`, with or without traffic.
- R7: With auto-cancel on, a cycle that produces a utilization interrupt restarts the interval count at zero. This restart takes precedence over an expiry in the same cycle.
- R8: While `en_i` is low, neither interrupt fires. The frame counter, interval counter and traffic flag are held at zero, and `band_o` keeps its value.
- R9: Frame completions alone never cause a timer pulse, and timer expiries never cause a utilization pulse.
- R10: After reset, both interrupts are low and `band_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable for both interrupt sources |
| frame_i | input | 1 | One-cycle strobe per completed frame |
| util_pct_i | input | 7 | Current link utilization, 0 to 100 |
| us_tick_i | input | 1 | One-cycle strobe every microsecond |
| lim_i | input | 21 | Band limits A, B, C |
| thr_i | input | 64 | Frame-count thresholds A to D |
| interval_i | input | 16 | Timer interval in ticks, 0 disables |
| cont_en_i | input | 1 | Continuous timer mode |
| ac_en_i | input | 1 | Auto-cancel on utilization interrupt |
| util_irq_o | output | 1 | Utilization interrupt pulse |
| tmr_irq_o | output | 1 | Timer interrupt pulse |
| band_o | output | 2 | Band chosen at the last frame strobe |

## Verification
Every result is one register stage away from its cause. The utilization pulse and the new band appear in the cycle after the frame strobe, and the timer pulse appears in the cycle after the expiring tick. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge, so each sample lines up with the stimulus of the previous cycle. For timer tests, the bench counts the pulses over a fixed window of cycles and records the index of the first one. It compares both against cycle numbers worked out by hand from the tick pattern and the restart rules.

// File: rtl/irqmod_pkg.sv
`timescale 1ns/1ps
package irqmod_pkg;
    localparam int PCT_W     = 7;
    localparam int CNT_W     = 16;
    localparam int TMR_W     = 16;
    localparam int NUM_LIM   = 3;
    localparam int NUM_BANDS = NUM_LIM + 1;
    localparam int BAND_W    = $clog2(NUM_BANDS);

    typedef enum logic [1:0] {
        BAND_A = 2'd0,
        BAND_B = 2'd1,
        BAND_C = 2'd2,
        BAND_D = 2'd3
    } band_e;
endpackage

// File: rtl/irqmod_band_sel.sv
`timescale 1ns/1ps
module irqmod_band_sel #(
    parameter int PCT_W   = 7,
    parameter int NUM_LIM = 3,
    parameter int BAND_W  = $clog2(NUM_LIM + 1)
) (
    input  logic [PCT_W-1:0]         util_i,
    input  logic [NUM_LIM*PCT_W-1:0] lim_i,
    output logic [BAND_W-1:0]        band_o
);
    logic [NUM_LIM-1:0] at_or_below;

    for (genvar g = 0; g < NUM_LIM; g++) begin : g_cmp
        assign at_or_below[g] = (util_i <= lim_i[g*PCT_W +: PCT_W]);
    end

    // lowest matching band wins; none matching selects the top band
    always_comb begin
        band_o = BAND_W'(NUM_LIM);
        for (int i = NUM_LIM - 1; i >= 0; i--) begin
            if (at_or_below[i]) band_o = BAND_W'(i);
        end
    end
endmodule

// File: rtl/irqmod_util_trig.sv
`timescale 1ns/1ps
module irqmod_util_trig #(
    parameter int CNT_W     = 16,
    parameter int NUM_BANDS = 4,
    parameter int BAND_W    = $clog2(NUM_BANDS)
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       en_i,
    input  logic                       frame_i,
    input  logic [BAND_W-1:0]          band_sel_i,
    input  logic [NUM_BANDS*CNT_W-1:0] thr_i,
    output logic                       fire_d_o,
    output logic                       irq_o,
    output logic [BAND_W-1:0]          band_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BAND_W-1:0] band;
        logic              irq;
    } util_st_t;

    util_st_t st_d, st_q;
    logic [CNT_W-1:0] thr_arr [NUM_BANDS];
    logic [CNT_W-1:0] thr_sel;
    logic [CNT_W-1:0] cnt_inc;

    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_thr
        assign thr_arr[g] = thr_i[g*CNT_W +: CNT_W];
    end

    always_comb begin
        thr_sel = thr_arr[band_sel_i];
        cnt_inc = (st_q.cnt == '1) ? st_q.cnt : st_q.cnt + 1'b1;
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (frame_i) begin
            st_d.band = band_sel_i;
            if (cnt_inc >= thr_sel) begin
                st_d.irq = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fire_d_o = st_d.irq;
    assign irq_o    = st_q.irq;
    assign band_o   = st_q.band;
endmodule

// File: rtl/irqmod_interval_tmr.sv
`timescale 1ns/1ps
module irqmod_interval_tmr #(
    parameter int TMR_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             frame_i,
    input  logic [TMR_W-1:0] interval_i,
    input  logic             cont_i,
    input  logic             ac_i,
    input  logic             cancel_i,
    output logic             irq_o
);
    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic             seen;
        logic             irq;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    expire;

    always_comb begin
        expire    = ({1'b0, st_q.cnt} + 1'b1) >= {1'b0, interval_i};
        st_d      = st_q;
        st_d.irq  = 1'b0;
        st_d.seen = st_q.seen | frame_i;
        if (!en_i || interval_i == '0) begin
            st_d.cnt  = '0;
            st_d.seen = 1'b0;
        end else if (ac_i && cancel_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (expire) begin
                st_d.cnt  = '0;
                st_d.irq  = cont_i | st_q.seen | frame_i;
                st_d.seen = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/txq_irq_moderator.sv
`timescale 1ns/1ps
module txq_irq_moderator
    import irqmod_pkg::*;
#(
    parameter int P_PCT_W = PCT_W,
    parameter int P_CNT_W = CNT_W,
    parameter int P_TMR_W = TMR_W,
    parameter int P_NLIM  = NUM_LIM,
    localparam int LBANDS = P_NLIM + 1,
    localparam int LBW    = $clog2(LBANDS)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      en_i,
    input  logic                      frame_i,
    input  logic [P_PCT_W-1:0]        util_pct_i,
    input  logic                      us_tick_i,
    input  logic [P_NLIM*P_PCT_W-1:0] lim_i,
    input  logic [LBANDS*P_CNT_W-1:0] thr_i,
    input  logic [P_TMR_W-1:0]        interval_i,
    input  logic                      cont_en_i,
    input  logic                      ac_en_i,
    output logic                      util_irq_o,
    output logic                      tmr_irq_o,
    output logic [LBW-1:0]            band_o
);
    logic [LBW-1:0] band_now;
    logic           util_fire_d;

    irqmod_band_sel #(.PCT_W(P_PCT_W), .NUM_LIM(P_NLIM), .BAND_W(LBW)) u_band (
        .util_i (util_pct_i),
        .lim_i  (lim_i),
        .band_o (band_now)
    );

    irqmod_util_trig #(.CNT_W(P_CNT_W), .NUM_BANDS(LBANDS), .BAND_W(LBW)) u_util (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .frame_i    (frame_i),
        .band_sel_i (band_now),
        .thr_i      (thr_i),
        .fire_d_o   (util_fire_d),
        .irq_o      (util_irq_o),
        .band_o     (band_o)
    );

    irqmod_interval_tmr #(.TMR_W(P_TMR_W)) u_tmr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .tick_i     (us_tick_i),
        .frame_i    (frame_i),
        .interval_i (interval_i),
        .cont_i     (cont_en_i),
        .ac_i       (ac_en_i),
        .cancel_i   (util_fire_d),
        .irq_o      (tmr_irq_o)
    );
endmodule

// File: rtl/irqmod_chk.sv
`timescale 1ns/1ps
module irqmod_chk #(
    parameter int TW = 16,
    parameter int BW = 2
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          en_i,
    input logic          frame_i,
    input logic          us_tick_i,
    input logic [TW-1:0] interval_i,
    input logic          ac_en_i,
    input logic          util_irq_o,
    input logic          tmr_irq_o,
    input logic [BW-1:0] band_o
);
    // R2
    util_after_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        util_irq_o |-> $past(frame_i && en_i));

    // R1
    band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(frame_i && en_i) |=> $stable(band_o));

    // R4
    tmr_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_irq_o |-> ($past(us_tick_i) && $past(interval_i) != '0));

    // R8
    quiet_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!util_irq_o && !tmr_irq_o));

    // R7
    cancel_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ac_en_i && frame_i) |=> !(util_irq_o && tmr_irq_o));
endmodule

bind txq_irq_moderator irqmod_chk #(.TW(P_TMR_W), .BW(LBW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .frame_i    (frame_i),
    .us_tick_i  (us_tick_i),
    .interval_i (interval_i),
    .ac_en_i    (ac_en_i),
    .util_irq_o (util_irq_o),
    .tmr_irq_o  (tmr_irq_o),
    .band_o     (band_o)
);

// File: tb/sim_txq_irq_moderator.sv
`timescale 1ns/1ps
module sim_txq_irq_moderator;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        en_i = 1'b0;
    logic        frame_i = 1'b0;
    logic [6:0]  util_pct_i = '0;
    logic        us_tick_i = 1'b0;
    logic [20:0] lim_i = {7'd80, 7'd50, 7'd20};
    logic [63:0] thr_i = {16'd1, 16'd1, 16'd2, 16'd3};
    logic [15:0] interval_i = '0;
    logic        cont_en_i = 1'b0;
    logic        ac_en_i = 1'b0;
    logic        util_irq_o, tmr_irq_o;
    logic [1:0]  band_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk_i = ~clk_i;

    txq_irq_moderator u0 (.*);

    // {util[9:3], expected band[2:1], expected util pulse[0]}
    localparam logic [9:0] VEC [12] = '{
        {7'd10,  2'd0, 1'b0}, {7'd20, 2'd0, 1'b0}, {7'd20, 2'd0, 1'b1},
        {7'd21,  2'd1, 1'b0}, {7'd50, 2'd1, 1'b1}, {7'd51, 2'd2, 1'b1},
        {7'd80,  2'd2, 1'b1}, {7'd81, 2'd3, 1'b1}, {7'd100, 2'd3, 1'b1},
        {7'd0,   2'd0, 1'b0}, {7'd65, 2'd2, 1'b1}, {7'd5,  2'd0, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic fr, input logic [6:0] u, input logic tk);
        frame_i = fr; util_pct_i = u; us_tick_i = tk;
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic restart();
        en_i = 1'b0;
        step(1'b0, 7'd0, 1'b0);
        en_i = 1'b1;
    endtask

    // tick_odd: tick only in odd cycles; frame_at: cycle index with a frame (0 = none)
    task automatic window(input int n, input int frame_at, input bit tick_odd,
                          input logic [6:0] u, output int tcnt, output int tfirst,
                          output int ucnt);
        tcnt = 0; tfirst = 0; ucnt = 0;
        for (int i = 1; i <= n; i++) begin
            step(i == frame_at, u, tick_odd ? logic'(i % 2) : 1'b1);
            if (tmr_irq_o) begin
                tcnt++;
                if (tfirst == 0) tfirst = i;
            end
            if (util_irq_o) ucnt++;
        end
        step(1'b0, 7'd0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int tc, tf, uc;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R10
        chk("R10 util", util_irq_o, 0);
        chk("R10 tmr", tmr_irq_o, 0);
        chk("R10 band", band_o, 0);

        en_i = 1'b1;
        for (int i = 0; i < 12; i++) begin
            step(1'b1, VEC[i][9:3], 1'b0);
            chk($sformatf("R1 band vec%0d", i), band_o, VEC[i][2:1]);
            chk($sformatf("R2 R3 util vec%0d", i), util_irq_o, VEC[i][0]);
            chk($sformatf("R4 R9 tmr vec%0d", i), tmr_irq_o, 0);
        end
        step(1'b0, 7'd0, 1'b0);

        thr_i = {4{16'd1000}};
        interval_i = 16'd4;
        restart();
        window(12, 0, 1'b0, 7'd10, tc, tf, uc);
        chk("R5 no traffic pulses", tc, 0);
        restart();
        window(12, 2, 1'b0, 7'd10, tc, tf, uc);
        chk("R5 traffic pulses", tc, 1);
        chk("R5 traffic first", tf, 4);
        chk("R9 no util from timer", uc, 0);

        cont_en_i = 1'b1;
        restart();
        window(12, 0, 1'b0, 7'd10, tc, tf, uc);
        chk("R6 continuous pulses", tc, 3);
        chk("R6 continuous first", tf, 4);

        thr_i = {4{16'd1}};
        ac_en_i = 1'b1;
        restart();
        window(12, 3, 1'b0, 7'd10, tc, tf, uc);
        chk("R7 cancel first", tf, 7);
        chk("R7 cancel pulses", tc, 2);
        chk("R9 util separate", uc, 1);
        ac_en_i = 1'b0;
        restart();
        window(12, 3, 1'b0, 7'd10, tc, tf, uc);
        chk("R7 no cancel first", tf, 4);

        interval_i = 16'd0;
        restart();
        window(12, 0, 1'b0, 7'd10, tc, tf, uc);
        chk("R4 interval zero", tc, 0);
        interval_i = 16'd3;
        restart();
        window(12, 0, 1'b1, 7'd10, tc, tf, uc);
        chk("R4 sparse ticks first", tf, 5);

        restart();
        step(1'b1, 7'd10, 1'b0);
        chk("R1 band before off", band_o, 0);
        en_i = 1'b0;
        interval_i = 16'd2;
        tc = 0; uc = 0;
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 7'd90, 1'b1);
            if (tmr_irq_o) tc++;
            if (util_irq_o) uc++;
        end
        chk("R8 no tmr when off", tc, 0);
        chk("R8 no util when off", uc, 0);
        chk("R8 band held", band_o, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule